// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps the stores of an out-of-order core away from memory until each one commits. Decode claims a slot for every store in program order. The store's address and its data then arrive as two separate micro-operations, and they may come in either order. When the store commits, its speculative bit clears. Committed stores leave the head of the buffer one per cycle through a plain cache write port with a valid/ready handshake. A store that is aborted is dropped and never reaches the cache.

Loads query the buffer at the same time as the cache. Each load presents its address and its age, which is the allocation position a store decoded just after that load would have received. The buffer compares the address only against stores older than the load. The youngest matching store supplies the data and takes precedence over the cache. If that store has its address but not yet its data, the query reports a stall. With no match the query reports a miss, and the load takes its data from the cache.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset the buffer is empty and `alloc_ready` is 1. Each accepted allocation receives position `alloc_pos` (IW+1 bits: low IW bits are the slot, top bit a wrap flag), and successive allocations take successive positions modulo 2*DEPTH.
- R2: An address write changes only the target entry's address, and a data write changes only its data. Either may come first. Writes to an entry that is aborted or already committed are ignored.
- R3: A commit is accepted only for a valid, speculative entry that holds both its address and its data. Acceptance clears the speculative bit and makes the entry eligible to drain.
- R4: A commit to an entry that lacks its address or its data has no effect: nothing drains from that entry.
- R5: An abort of a valid speculative entry clears its valid bit. That entry never drains and never forwards, and its slot is freed silently once it reaches the head.
- R6: A load that matches a buffered older store returns the buffer's data with `ld_hit`=1, whether or not the store has committed.
- R7: A store counts as older than a load when its position lies between the buffer head and the load's `ld_age`. Among older stores with the same address, the youngest supplies the data. Younger stores are ignored.
- R8: If the youngest matching older store has its address but not its data, `ld_stall`=1 and `ld_hit`=0.
- R9: With no matching older store, `ld_hit`=0 and `ld_stall`=0 (miss). With `ld_valid`=0, both are 0.
- R10: Committed entries drain strictly in allocation order, at most one per cycle. `dr_valid`, `dr_addr` and `dr_data` hold steady until `dr_ready` is 1, and the entry is freed on that cycle.
- R11: With DEPTH entries occupied, `alloc_ready`=0 and an allocation request is ignored (the next position does not advance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a slot for a newly decoded store |
| alloc_ready | output | 1 | A slot is free |
| alloc_pos | output | IW+1 | Position the next allocation receives |
| addr_valid | input | 1 | Store-address micro-op |
| addr_idx | input | IW | Target slot of the address write |
| addr_value | input | AW | Store address |
| data_valid | input | 1 | Store-data micro-op |
| data_idx | input | IW | Target slot of the data write |
| data_value | input | DW | Store data |
| commit_valid | input | 1 | Commit request |
| commit_idx | input | IW | Slot to commit |
| abort_valid | input | 1 | Abort request |
| abort_idx | input | IW | Slot to abort |
| ld_valid | input | 1 | Load query present |
| ld_addr | input | AW | Load address |
| ld_age | input | IW+1 | Load age, as an allocation position |
| ld_hit | output | 1 | Forwarded data valid |
| ld_stall | output | 1 | Matching store still lacks its data |
| ld_data | output | DW | Forwarded data |
| dr_valid | output | 1 | Committed store offered to the cache |
| dr_ready | input | 1 | Cache accepts the offered store |
| dr_addr | output | AW | Drain address |
| dr_data | output | DW | Drain data |

## Verification
On every cycle the assertions check four things. Occupancy never exceeds DEPTH. An offered drain stays valid and unchanged while the cache holds it off. A load query never reports hit and stall together, and a cycle with no query reports neither. An accepted allocation always leaves the buffer non-empty.

Some behaviour only the directed scenarios can show, because the expected result depends on what was stored earlier:
- which store wins when several older entries share an address;
- that younger stores are excluded;
- that commits arriving too early are ignored;
- that aborted stores vanish;
- the drain order and the exact forwarded values.

// File: rtl/spec_store_buffer.sv
module spec_store_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  output logic                    alloc_ready,
  output logic [$clog2(DEPTH):0]  alloc_pos,
  input  logic                    addr_valid,
  input  logic [$clog2(DEPTH)-1:0] addr_idx,
  input  logic [AW-1:0]           addr_value,
  input  logic                    data_valid,
  input  logic [$clog2(DEPTH)-1:0] data_idx,
  input  logic [DW-1:0]           data_value,
  input  logic                    commit_valid,
  input  logic [$clog2(DEPTH)-1:0] commit_idx,
  input  logic                    abort_valid,
  input  logic [$clog2(DEPTH)-1:0] abort_idx,
  input  logic                    ld_valid,
  input  logic [AW-1:0]           ld_addr,
  input  logic [$clog2(DEPTH):0]  ld_age,
  output logic                    ld_hit,
  output logic                    ld_stall,
  output logic [DW-1:0]           ld_data,
  output logic                    dr_valid,
  input  logic                    dr_ready,
  output logic [AW-1:0]           dr_addr,
  output logic [DW-1:0]           dr_data
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic [DEPTH-1:0] e_val, e_spec, e_ha, e_hd;
  logic [AW-1:0]    e_tag [DEPTH];
  logic [DW-1:0]    e_dat [DEPTH];
  logic [PW-1:0]    head, tail, occ;
  logic [IW-1:0]    hidx, tidx;
  logic             alloc_fire, pop;

  assign occ         = tail - head;
  assign hidx        = head[IW-1:0];
  assign tidx        = tail[IW-1:0];
  assign alloc_ready = (occ != PW'(DEPTH));
  assign alloc_pos   = tail;
  assign alloc_fire  = alloc_valid && alloc_ready;

  assign dr_valid = (occ != '0) && e_val[hidx] && !e_spec[hidx];
  assign dr_addr  = e_tag[hidx];
  assign dr_data  = e_dat[hidx];
  assign pop      = (occ != '0) && (!e_val[hidx] || (dr_valid && dr_ready));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      e_val <= '0;
      e_spec <= '0;
      e_ha  <= '0;
      e_hd  <= '0;
    end else begin
      if (pop)        head <= head + 1'b1;
      if (alloc_fire) tail <= tail + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (addr_valid && addr_idx == IW'(i) && e_val[i] && e_spec[i]) begin
          e_tag[i] <= addr_value;
          e_ha[i]  <= 1'b1;
        end
        if (data_valid && data_idx == IW'(i) && e_val[i] && e_spec[i]) begin
          e_dat[i] <= data_value;
          e_hd[i]  <= 1'b1;
        end
        if (commit_valid && commit_idx == IW'(i) && e_val[i] && e_spec[i] && e_ha[i] && e_hd[i])
          e_spec[i] <= 1'b0;
        if (abort_valid && abort_idx == IW'(i) && e_val[i] && e_spec[i])
          e_val[i] <= 1'b0;
        if (pop && hidx == IW'(i))
          e_val[i] <= 1'b0;
        if (alloc_fire && tidx == IW'(i)) begin
          e_val[i]  <= 1'b1;
          e_spec[i] <= 1'b1;
          e_ha[i]   <= 1'b0;
          e_hd[i]   <= 1'b0;
        end
      end
    end
  end

  logic [PW-1:0] span, lim;
  logic [IW-1:0] slot;
  logic          found, found_hd;
  logic [DW-1:0] found_dat;

  assign span = ld_age - head;
  assign lim  = (span <= occ) ? span : '0;

  always_comb begin
    found     = 1'b0;
    found_hd  = 1'b0;
    found_dat = '0;
    slot      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = hidx + IW'(k);
      if (PW'(k) < lim && e_val[slot] && e_ha[slot] && e_tag[slot] == ld_addr) begin
        found     = 1'b1;
        found_hd  = e_hd[slot];
        found_dat = e_dat[slot];
      end
    end
  end

  assign ld_hit   = ld_valid && found && found_hd;
  assign ld_stall = ld_valid && found && !found_hd;
  assign ld_data  = ld_hit ? found_dat : '0;
endmodule

// File: rtl/spec_store_buffer_chk.sv
module spec_store_buffer_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   alloc_valid,
  input logic                   alloc_ready,
  input logic                   ld_valid,
  input logic                   ld_hit,
  input logic                   ld_stall,
  input logic                   dr_valid,
  input logic                   dr_ready,
  input logic [AW-1:0]          dr_addr,
  input logic [DW-1:0]          dr_data,
  input logic [$clog2(DEPTH):0] occ
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH)+1)'(DEPTH)); // R11
  AST_ALLOC_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |=> occ != '0); // R1
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data)); // R10
  AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_stall)); // R8
  AST_IDLE_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !ld_hit && !ld_stall); // R9
endmodule

bind spec_store_buffer spec_store_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .ld_valid(ld_valid), .ld_hit(ld_hit), .ld_stall(ld_stall),
  .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data),
  .occ(occ)
);

// File: tb/tb_spec_store_buffer.sv
`timescale 1ns/1ps
module tb_spec_store_buffer;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [PW-1:0] alloc_pos;
  logic addr_valid = 0; logic [IW-1:0] addr_idx = 0; logic [AW-1:0] addr_value = 0;
  logic data_valid = 0; logic [IW-1:0] data_idx = 0; logic [DW-1:0] data_value = 0;
  logic commit_valid = 0; logic [IW-1:0] commit_idx = 0;
  logic abort_valid = 0; logic [IW-1:0] abort_idx = 0;
  logic ld_valid = 0; logic [AW-1:0] ld_addr = 0; logic [PW-1:0] ld_age = 0;
  logic ld_hit, ld_stall; logic [DW-1:0] ld_data;
  logic dr_valid, dr_ready = 0; logic [AW-1:0] dr_addr; logic [DW-1:0] dr_data;

  int n_chk = 0, n_bad = 0;
  logic [PW-1:0] pos = 0;

  always #2.5 clk = ~clk;

  spec_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    alloc_valid = 0; addr_valid = 0; data_valid = 0;
    commit_valid = 0; abort_valid = 0;
  endtask

  task automatic alloc(output logic [IW-1:0] idx);
    check("R1 alloc_pos", alloc_pos, pos);
    idx = pos[IW-1:0];
    alloc_valid = 1; tick(); pos = pos + 1'b1;
  endtask

  task automatic wr_addr(input logic [IW-1:0] i, input logic [AW-1:0] a);
    addr_valid = 1; addr_idx = i; addr_value = a; tick();
  endtask
  task automatic wr_data(input logic [IW-1:0] i, input logic [DW-1:0] d);
    data_valid = 1; data_idx = i; data_value = d; tick();
  endtask
  task automatic commit(input logic [IW-1:0] i);
    commit_valid = 1; commit_idx = i; tick();
  endtask
  task automatic abort(input logic [IW-1:0] i);
    abort_valid = 1; abort_idx = i; tick();
  endtask
  task automatic settle();
    for (int k = 0; k < DEPTH + 1; k++) tick();
  endtask

  task automatic query(input logic [AW-1:0] a, input logic [PW-1:0] age,
                       input string req, input logic eh, input logic es, input logic [DW-1:0] ed);
    ld_valid = 1; ld_addr = a; ld_age = age; #1;
    check({req, " hit"}, ld_hit, eh);
    check({req, " stall"}, ld_stall, es);
    if (eh) check({req, " data"}, ld_data, ed);
    ld_valid = 0; #1;
  endtask

  task automatic t_reset();
    check("R1 reset alloc_ready", alloc_ready, 1);
    check("R1 reset alloc_pos", alloc_pos, 0);
    check("R10 reset dr_valid", dr_valid, 0);
    query(16'h0000, 0, "R9 reset", 0, 0, 0);
  endtask

  task automatic t_data_first();
    logic [IW-1:0] s;
    alloc(s);
    wr_data(s, 32'hDEAD_0001);
    wr_addr(s, 16'h0100);
    wr_addr(s, 16'h0100);
    commit(s);
    check("R3 drain after commit", dr_valid, 1);
    check("R2 drain addr", dr_addr, 16'h0100);
    check("R2 drain data", dr_data, 32'hDEAD_0001);
    dr_ready = 1; tick(); dr_ready = 0;
    check("R10 freed", dr_valid, 0);
    wr_data(s, 32'h1234_5678);
    query(16'h0100, pos, "R2 write to freed slot ignored", 0, 0, 0);
  endtask

  task automatic t_early_commit();
    logic [IW-1:0] s;
    alloc(s);
    wr_addr(s, 16'h0200);
    commit(s);
    check("R4 no drain without data", dr_valid, 0);
    wr_data(s, 32'h0000_00AA);
    check("R4 still speculative", dr_valid, 0);
    commit(s);
    check("R3 drain", dr_valid, 1);
    check("R3 drain data", dr_data, 32'h0000_00AA);
    dr_ready = 1; tick(); dr_ready = 0;
  endtask

  task automatic t_abort();
    logic [IW-1:0] s;
    alloc(s);
    wr_addr(s, 16'h0300);
    wr_data(s, 32'h0000_0333);
    abort(s);
    query(16'h0300, pos, "R5 aborted no forward", 0, 0, 0);
    commit(s);
    check("R5 aborted never drains", dr_valid, 0);
    settle();
    check("R5 slot freed", alloc_ready, 1);
  endtask

  task automatic t_forward();
    logic [IW-1:0] a, b, c, o;
    logic [PW-1:0] p0, p2;
    p0 = pos;
    alloc(a); wr_addr(a, 16'h0400); wr_data(a, 32'hA);
    alloc(o); wr_addr(o, 16'h0555); wr_data(o, 32'h5);
    alloc(b); wr_addr(b, 16'h0400); wr_data(b, 32'hB);
    p2 = pos;
    alloc(c); wr_addr(c, 16'h0400); wr_data(c, 32'hC);
    query(16'h0400, p2, "R7 youngest older", 1, 0, 32'hB);
    query(16'h0400, pos, "R7 all older", 1, 0, 32'hC);
    query(16'h0400, p0, "R7 none older", 0, 0, 0);
    query(16'h0777, pos, "R9 miss", 0, 0, 0);
    commit(a);
    query(16'h0400, p0 + 1'b1, "R6 committed still forwards", 1, 0, 32'hA);
    abort(o); abort(b); abort(c);
    dr_ready = 1; settle(); dr_ready = 0;
    check("R10 emptied", alloc_ready, 1);
  endtask

  task automatic t_stall();
    logic [IW-1:0] a, b;
    alloc(a); wr_addr(a, 16'h0600); wr_data(a, 32'h66);
    alloc(b); wr_addr(b, 16'h0600);
    query(16'h0600, pos, "R8 stall", 0, 1, 0);
    wr_data(b, 32'h77);
    query(16'h0600, pos, "R8 resolved", 1, 0, 32'h77);
    abort(a); abort(b); settle();
  endtask

  task automatic t_full_and_order();
    logic [IW-1:0] s[DEPTH];
    for (int k = 0; k < DEPTH; k++) begin
      alloc(s[k]); wr_addr(s[k], AW'(16'h0800 + k)); wr_data(s[k], DW'(32'h900 + k));
    end
    check("R11 full not ready", alloc_ready, 0);
    alloc_valid = 1; tick();
    check("R11 ignored alloc", alloc_pos, pos);
    for (int k = 0; k < DEPTH; k++) commit(s[k]);
    check("R10 head offered", dr_addr, 16'h0800);
    tick();
    check("R10 held valid", dr_valid, 1);
    check("R10 held addr", dr_addr, 16'h0800);
    dr_ready = 1;
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      check("R10 order addr", dr_addr, AW'(16'h0800 + k));
      check("R10 order data", dr_data, DW'(32'h900 + k));
      tick();
    end
    dr_ready = 0;
    check("R10 drained", dr_valid, 0);
    check("R11 ready again", alloc_ready, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_data_first();
    t_early_commit();
    t_abort();
    t_forward();
    t_stall();
    t_full_and_order();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule